// File: doc/BRIEF.md
# Oscillator Stabilization and Clock Switch Controller

This block chooses the source of a small system's clock. When reset is released, the system clock comes from an internal oscillator that always runs. Software starts the external crystal oscillator by clearing a stop bit. A counter in the external clock domain then counts oscillator cycles. Its progress is shown to software as a thermometer of power-of-two milestones.

Software picks one milestone as the release threshold and writes a switch request. The request takes effect only once the selected milestone has been reached. A glitch-free multiplexer then hands the system clock over to the external source. A read-only status bit reports which source is actually driving the clock. The input `ext_alive` stands in for a running crystal: counting advances only while it is high.

The register bus is synchronous to `clk_int`. Writes are single-cycle strobes. Reads are combinational from the address.

Top module: `clk_switch_ctrl`

## Requirements
- R1: After reset, `sys_clk` follows `clk_int`. The control register (address 1) reads 0x80, with the stop bit set. The progress register (address 3) and the select register (address 4) both read 0x00.
- R2: Bit 7 of the control register is the external oscillator stop bit. Writing 0 to it starts the counter, which counts from zero.
- R3: The progress register has one flag per milestone. Bit 7 is 2^8 cycles, bit 6 is 2^9, bit 5 is 2^10, bit 4 is 2^11, bit 3 is 2^13, bit 2 is 2^15, bit 1 is 2^17 and bit 0 is 2^18. The flags fill from bit 7 downward, so after 2^10 cycles the register reads 0xE0 and after 2^11 cycles it reads 0xF0.
- R4: Bits [2:0] of the wait register (address 2) select the release threshold and read back as written. Values 0 to 7 map to the milestones in ascending order, so 0 selects 2^8, 2 selects 2^10 and 3 selects 2^11. Flags past the threshold keep filling.
- R5: While the stop bit is 1, the progress register reads 0x00. After the stop bit is cleared again, counting restarts from zero.
- R6: Bit 4 of the select register is the switch request and reads back as written. Until the selected milestone flag is set, the request leaves `sys_clk` on `clk_int` and the status bit at 0.
- R7: Bit 5 of the select register is read-only. It reads 1 only while `sys_clk` runs from `clk_ext`. If the request or the milestone is withdrawn, the clock returns to `clk_int` and the bit clears.
- R8: The multiplexer never enables both clock gates at once. Each source is disabled on its own falling edge before the other source is enabled.
- R9: The mode register (address 0) reads back bit 0 (crystal select) and bit 1 (high gain, for frequencies of 10 MHz and above). These two bits drive `xtal_sel_o` and `hi_gain_o`.
- R10: While `ext_alive` is 0, the counter holds its value and no new flags appear.
- R11: Writes to the progress register are ignored. A write to bit 5 of the select register has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_int | input | 1 | Internal oscillator clock; also clocks the register bus |
| clk_ext | input | 1 | External oscillator clock |
| rst | input | 1 | Synchronous active-high reset |
| ext_alive | input | 1 | Stub: high while the external oscillator produces valid cycles |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 3 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for `bus_addr` |
| xtal_sel_o | output | 1 | Crystal select setting |
| hi_gain_o | output | 1 | High-gain amplifier setting |
| sys_clk | output | 1 | Selected system clock |

## Verification
The assertions check the following on every cycle:
- the two clock gates are never enabled at the same time;
- the progress register always holds a valid thermometer code;
- the status bit rises only while the selected milestone is met;
- the reset values of the stop bit and the internal-clock gate.

The bench scenarios cover the behaviour that depends on elapsed time: the milestone values after a given number of external cycles, the pause while `ext_alive` is low, and counting restarting from zero after a stop. They also show `sys_clk` following each source edge for edge, and that ignored writes change nothing.

// File: rtl/clkctl_pkg.sv
package clkctl_pkg;
    localparam int NFLAG  = 8;
    localparam int CNT_W  = 19;
    localparam int DATA_W = 8;
    localparam int ADDR_W = 3;

    typedef enum logic [ADDR_W-1:0] {
        A_MODE = 3'd0,
        A_CTRL = 3'd1,
        A_WAIT = 3'd2,
        A_PROG = 3'd3,
        A_SEL  = 3'd4
    } reg_addr_e;

    typedef struct packed {
        logic       xtal_sel;
        logic       hi_gain;
        logic       stop;
        logic [2:0] wait_sel;
        logic       req;
    } ctl_regs_t;

    // Exponent of milestone k, with k = 0 being the smallest milestone.
    function automatic int milestone_exp(input int k);
        case (k)
            0: return 8;
            1: return 9;
            2: return 10;
            3: return 11;
            4: return 13;
            5: return 15;
            6: return 17;
            default: return 18;
        endcase
    endfunction

    localparam logic [CNT_W-1:0] CNT_SAT = CNT_W'(1) << milestone_exp(NFLAG-1);
endpackage

// File: rtl/cc_sync2.sv
module cc_sync2 #(
    parameter int         W       = 1,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] s1;

    always_ff @(posedge clk) begin
        if (rst) begin
            s1 <= RST_VAL;
            q  <= RST_VAL;
        end else begin
            s1 <= d;
            q  <= s1;
        end
    end
endmodule

// File: rtl/cc_stab_counter.sv
module cc_stab_counter
    import clkctl_pkg::*;
(
    input  logic             clk_ext,
    input  logic             rst,
    input  logic             stop_async,
    input  logic             alive,
    output logic [NFLAG-1:0] flags_o
);
    logic             stop_e;
    logic [CNT_W-1:0] cnt;
    logic [NFLAG-1:0] flags_d;

    cc_sync2 #(.W(1), .RST_VAL(1'b1)) u_stop_sync (
        .clk (clk_ext),
        .rst (rst),
        .d   (stop_async),
        .q   (stop_e)
    );

    always_ff @(posedge clk_ext) begin
        if (rst || stop_e)
            cnt <= '0;
        else if (alive && cnt != CNT_SAT)
            cnt <= cnt + 1'b1;
    end

    // Bit NFLAG-1 holds the smallest milestone.
    always_comb begin
        for (int k = 0; k < NFLAG; k++)
            flags_d[NFLAG-1-k] = (cnt >= (CNT_W'(1) << milestone_exp(k)));
    end

    always_ff @(posedge clk_ext) begin
        if (rst || stop_e)
            flags_o <= '0;
        else
            flags_o <= flags_d;
    end
endmodule

// File: rtl/cc_glitch_mux.sv
module cc_glitch_mux (
    input  logic clk_a,
    input  logic clk_b,
    input  logic rst,
    input  logic sel_b,
    output logic gate_a,
    output logic gate_b,
    output logic clk_o
);
    logic a_s1, b_s1;

    always_ff @(posedge clk_a) begin
        if (rst) a_s1 <= 1'b1;
        else     a_s1 <= ~sel_b & ~gate_b;
    end

    always_ff @(negedge clk_a) begin
        if (rst) gate_a <= 1'b1;
        else     gate_a <= a_s1;
    end

    always_ff @(posedge clk_b) begin
        if (rst) b_s1 <= 1'b0;
        else     b_s1 <= sel_b & ~gate_a;
    end

    always_ff @(negedge clk_b) begin
        if (rst) gate_b <= 1'b0;
        else     gate_b <= b_s1;
    end

    assign clk_o = (clk_a & gate_a) | (clk_b & gate_b);
endmodule

// File: rtl/clk_switch_ctrl.sv
module clk_switch_ctrl
    import clkctl_pkg::*;
(
    input  logic              clk_int,
    input  logic              clk_ext,
    input  logic              rst,
    input  logic              ext_alive,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              xtal_sel_o,
    output logic              hi_gain_o,
    output logic              sys_clk
);
    ctl_regs_t        regs;
    logic [NFLAG-1:0] flags_ext, flags_int, stat_flags;
    logic             gate_int, gate_ext, ext_on, ready, want;

    always_ff @(posedge clk_int) begin
        if (rst) begin
            regs <= '{xtal_sel: 1'b0, hi_gain: 1'b0, stop: 1'b1,
                      wait_sel: 3'd0, req: 1'b0};
        end else if (bus_we) begin
            case (reg_addr_e'(bus_addr))
                A_MODE: begin
                    regs.xtal_sel <= bus_wdata[0];
                    regs.hi_gain  <= bus_wdata[1];
                end
                A_CTRL:  regs.stop     <= bus_wdata[7];
                A_WAIT:  regs.wait_sel <= bus_wdata[2:0];
                A_SEL:   regs.req      <= bus_wdata[4];
                default: ;
            endcase
        end
    end

    cc_stab_counter u_cnt (
        .clk_ext    (clk_ext),
        .rst        (rst),
        .stop_async (regs.stop),
        .alive      (ext_alive),
        .flags_o    (flags_ext)
    );

    cc_sync2 #(.W(NFLAG), .RST_VAL('0)) u_flag_sync (
        .clk (clk_int),
        .rst (rst),
        .d   (flags_ext),
        .q   (flags_int)
    );

    assign stat_flags = flags_int & {NFLAG{~regs.stop}};
    assign ready      = stat_flags[NFLAG-1-int'(regs.wait_sel)];
    assign want       = regs.req & ready;

    cc_glitch_mux u_mux (
        .clk_a  (clk_int),
        .clk_b  (clk_ext),
        .rst    (rst),
        .sel_b  (want),
        .gate_a (gate_int),
        .gate_b (gate_ext),
        .clk_o  (sys_clk)
    );

    cc_sync2 #(.W(1), .RST_VAL(1'b0)) u_on_sync (
        .clk (clk_int),
        .rst (rst),
        .d   (gate_ext),
        .q   (ext_on)
    );

    always_comb begin
        case (reg_addr_e'(bus_addr))
            A_MODE:  bus_rdata = {6'b0, regs.hi_gain, regs.xtal_sel};
            A_CTRL:  bus_rdata = {regs.stop, 7'b0};
            A_WAIT:  bus_rdata = {5'b0, regs.wait_sel};
            A_PROG:  bus_rdata = stat_flags;
            A_SEL:   bus_rdata = {2'b0, ext_on, regs.req, 4'b0};
            default: bus_rdata = '0;
        endcase
    end

    assign xtal_sel_o = regs.xtal_sel;
    assign hi_gain_o  = regs.hi_gain;
endmodule

// File: rtl/clk_switch_ctrl_chk.sv
module clk_switch_ctrl_chk (
    input logic       clk_int,
    input logic       rst,
    input logic       gate_int,
    input logic       gate_ext,
    input logic       stop_q,
    input logic [7:0] stat_flags,
    input logic       ext_on,
    input logic       ready
);
    // R8: the two clock gates are never enabled together
    p_gates_exclusive_r8: assert property (@(posedge clk_int) disable iff (rst)
        !(gate_int && gate_ext));

    // R3: the progress value is always a thermometer filled from bit 7
    p_thermometer_r3: assert property (@(posedge clk_int) disable iff (rst)
        stat_flags == ~(8'hFF >> $countones(stat_flags)));

    // R6: the status bit rises only while the selected milestone is met
    p_no_early_switch_r6: assert property (@(posedge clk_int) disable iff (rst)
        $rose(ext_on) |-> ready);

    // R1: reset selects the internal clock gate
    p_reset_gate_r1: assert property (@(posedge clk_int)
        rst |=> gate_int);

    // R1: reset sets the stop bit
    p_reset_stop_r1: assert property (@(posedge clk_int)
        rst |=> stop_q);

    // R5: no progress flags while stopped
    p_stop_clears_r5: assert property (@(posedge clk_int) disable iff (rst)
        stop_q |-> $countones(stat_flags) == 0);
endmodule

bind clk_switch_ctrl clk_switch_ctrl_chk u_chk (
    .clk_int    (clk_int),
    .rst        (rst),
    .gate_int   (gate_int),
    .gate_ext   (gate_ext),
    .stop_q     (regs.stop),
    .stat_flags (stat_flags),
    .ext_on     (ext_on),
    .ready      (ready)
);

// File: tb/tb_clk_switch_ctrl.sv
`timescale 1ns/1ps
module tb_clk_switch_ctrl;
    logic       clk_int = 1'b0;
    logic       clk_ext = 1'b0;
    logic       rst = 1'b1;
    logic       ext_alive = 1'b1;
    logic       bus_we = 1'b0;
    logic [2:0] bus_addr = '0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic       xtal_sel_o, hi_gain_o, sys_clk;

    int n_checks = 0;
    int n_errors = 0;
    bit finished = 0;

    always #2 clk_int = ~clk_int;   // 250 MHz
    always #5 clk_ext = ~clk_ext;   // 100 MHz

    clk_switch_ctrl dut (
        .clk_int    (clk_int),
        .clk_ext    (clk_ext),
        .rst        (rst),
        .ext_alive  (ext_alive),
        .bus_we     (bus_we),
        .bus_addr   (bus_addr),
        .bus_wdata  (bus_wdata),
        .bus_rdata  (bus_rdata),
        .xtal_sel_o (xtal_sel_o),
        .hi_gain_o  (hi_gain_o),
        .sys_clk    (sys_clk)
    );

    task automatic check(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_errors++;
            $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk_int);
        bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk_int);
        bus_we = 1'b0;
    endtask

    task automatic rd_check(input string req, input logic [2:0] a, input logic [7:0] exp);
        @(negedge clk_int);
        bus_addr = a;
        #0.5;
        check(req, bus_rdata, exp);
    endtask

    task automatic wait_ext(input int n);
        repeat (n) @(posedge clk_ext);
    endtask

    // Counts the edges where sys_clk differs from the chosen source.
    task automatic check_follow(input string req, input bit use_ext);
        int bad = 0;
        for (int i = 0; i < 16; i++) begin
            if (use_ext) @(posedge clk_ext); else @(posedge clk_int);
            #0.5; if (sys_clk !== 1'b1) bad++;
            if (use_ext) @(negedge clk_ext); else @(negedge clk_int);
            #0.5; if (sys_clk !== 1'b0) bad++;
        end
        check(req, bad, 0);
    endtask

    task automatic t_reset();
        repeat (10) @(posedge clk_int);
        @(negedge clk_int); rst = 1'b0;
        rd_check("R1 ctrl reset", 3'd1, 8'h80);
        rd_check("R1 progress reset", 3'd3, 8'h00);
        rd_check("R1 select reset", 3'd4, 8'h00);
        check_follow("R1 sys_clk on internal", 1'b0);
    endtask

    task automatic t_mode();
        wr(3'd0, 8'h03);
        rd_check("R9 mode readback both", 3'd0, 8'h03);
        check("R9 pins both", {hi_gain_o, xtal_sel_o}, 2'b11);
        wr(3'd0, 8'h01);
        rd_check("R9 mode readback sel", 3'd0, 8'h01);
        check("R9 pins sel", {hi_gain_o, xtal_sel_o}, 2'b01);
    endtask

    task automatic t_count_and_switch();
        wr(3'd2, 8'h03);
        rd_check("R4 wait readback", 3'd2, 8'h03);
        wr(3'd1, 8'h00);
        rd_check("R2 stop cleared", 3'd1, 8'h00);
        wait_ext(200);
        rd_check("R2 below first milestone", 3'd3, 8'h00);
        ext_alive = 1'b0;
        wait_ext(500);
        rd_check("R10 paused no flags", 3'd3, 8'h00);
        ext_alive = 1'b1;
        wait_ext(900);
        rd_check("R3 after 2^10", 3'd3, 8'hE0);
        wr(3'd4, 8'h10);
        repeat (30) @(posedge clk_int);
        rd_check("R6 request held below threshold", 3'd4, 8'h10);
        check_follow("R6 still internal", 1'b0);
        wait_ext(1000);
        rd_check("R3 after 2^11", 3'd3, 8'hF0);
        repeat (30) @(posedge clk_int);
        rd_check("R7 status after switch", 3'd4, 8'h30);
        check_follow("R7 sys_clk on external", 1'b1);
    endtask

    task automatic t_stop_restart();
        wr(3'd1, 8'h80);
        rd_check("R5 flags cleared by stop", 3'd3, 8'h00);
        wait_ext(50);
        rd_check("R7 back to internal", 3'd4, 8'h10);
        check_follow("R7 sys_clk internal again", 1'b0);
        wr(3'd1, 8'h00);
        wait_ext(300);
        rd_check("R5 restart from zero", 3'd3, 8'h80);
        wr(3'd3, 8'hFF);
        rd_check("R11 progress write ignored", 3'd3, 8'h80);
        wr(3'd4, 8'h20);
        repeat (20) @(posedge clk_int);
        rd_check("R11 status bit write ignored", 3'd4, 8'h00);
    endtask

    task automatic t_low_threshold();
        wr(3'd2, 8'h00);
        wr(3'd4, 8'h10);
        repeat (30) @(posedge clk_int);
        rd_check("R4 threshold 2^8 switch", 3'd4, 8'h30);
        check_follow("R4 external at 2^8", 1'b1);
    endtask

    initial begin
        t_reset();
        t_mode();
        t_count_and_switch();
        t_stop_restart();
        t_low_threshold();
        if (!finished) begin
            finished = 1;
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end

    initial begin
        #400000;
        if (!finished) begin
            finished = 1;
            n_checks++; n_errors++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end
endmodule